// File: doc/BRIEF.md
# Predicate Bit Reduce-and-Pack Unit

This unit turns a vector of 4-bit condition fields into packed predicate bits held in 64-bit integer registers. A start pulse captures one operation: a 4-bit mask, a 4-bit mode pattern, a reduce-select bit, a 2-bit element-width code, a vector length, a base register number and a vector/scalar flag. After that capture the unit walks the elements one per clock. It presents the element number on a field read port and takes back that element's 4-bit condition field in the same cycle.

For each element, every field bit whose mask bit is set is tested for equality against the matching mode bit. The four tests are then folded into one predicate bit, using OR when reduce-select is 1 and AND when it is 0. A 64-bit accumulator collects the predicate bits for the register being built. It issues a write request once that register is complete.

In vector mode the element-width code sets how many predicate bits go into each register: 1, 2, 4 or 8. Bits above that group are written as zero. In scalar mode every predicate bit lands in the base register at the bit numbered by its element, and a single write is issued at the end.

Top module: `pbp_unit`

## Requirements
- R1: For each bit position k in 0..3, the per-bit term is true only when mask bit k is 1 and field bit k equals mode bit k. A term whose mask bit is 0 is false.
- R2: With reduce-select 1 the predicate bit is the OR of the four terms. With reduce-select 0 it is their AND, so a zero mask under AND gives 0.
- R3: Vector mode, width code 0: element i produces a write to register (base + i) mod 32. Its predicate bit is in bit 0 and bits 63..1 are zero.
- R4: Vector mode, width code 1: elements 2j and 2j+1 share register (base + j) mod 32. Element i's bit is at position i mod 2, and bits 63..2 are zero.
- R5: Vector mode, width code 2: four elements share register (base + i/4) mod 32. Element i's bit is at position i mod 4, and bits 63..4 are zero.
- R6: Vector mode, width code 3: eight elements share register (base + i/8) mod 32. Element i's bit is at position i mod 8, and bits 63..8 are zero.
- R7: Scalar mode: one write goes to the base register, with element i's predicate bit at position i and all other bits zero.
- R8: Element i is processed on the i-th clock after the start edge, counting from 0. During that cycle `fld_idx` equals i and `busy` is 1.
- R9: A write is issued when a vector group fills or when the last element is processed. A final partial group is written with the bits it already holds. `wr_valid` goes high in the cycle after that element is processed.
- R10: `done` is a one-cycle pulse in the cycle after the final write is visible. `wr_valid` is low during that pulse.
- R11: A length of zero produces no write, and `done` pulses in the cycle right after the start edge.
- R12: In scalar mode a length above 64 is treated as 64. In vector mode the full length is processed.
- R13: A start pulse while `busy` is 1 is ignored, and the running operation completes with its captured settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the operation settings when idle |
| cfg_mask | input | 4 | Per-bit enable for the comparison |
| cfg_mode | input | 4 | Pattern the field bits are compared with |
| cfg_any | input | 1 | 1: OR reduction, 0: AND reduction |
| cfg_width | input | 2 | Packing code: 2^code bits per register in vector mode |
| cfg_len | input | 7 | Number of elements |
| cfg_base | input | 5 | First destination register number |
| cfg_vec | input | 1 | 1: vector packing, 0: scalar packing |
| fld_idx | output | 7 | Number of the condition field being read |
| fld_bits | input | 4 | Condition field selected by fld_idx, same cycle |
| wr_valid | output | 1 | Write request strobe |
| wr_reg | output | 5 | Destination register number |
| wr_data | output | 64 | Value to write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are a final partial group, where the length is not a multiple of the group size, and a start pulse that arrives in the middle of a run. The stimulus sweeps lengths such as 13 and 100 across all four width codes, so that the last register is flushed before it is full. A base of 30 forces register numbers to wrap. One run raises start with different settings partway through, and the bench checks that every write still follows the captured settings. Scalar runs of 40 and 70 elements exercise bit positions above 8 and the clamp at 64.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } pbp_state_e;

  // one predicate bit from a field
  function automatic logic fold_terms(input logic [3:0] terms, input logic use_or);
    return use_or ? (|terms) : (&terms);
  endfunction

  // group size in vector mode, as a mask of the slot bits
  function automatic logic [6:0] slot_mask(input logic [1:0] code);
    return 7'((7'd1 << code) - 7'd1);
  endfunction

endpackage

// File: rtl/pbp_reduce.sv
module pbp_reduce (
  input  logic [3:0] mask,
  input  logic [3:0] mode,
  input  logic [3:0] field,
  input  logic       use_or,
  output logic [3:0] terms,
  output logic       pred
);
  import pbp_pkg::*;

  for (genvar k = 0; k < 4; k++) begin : g_term
    assign terms[k] = mask[k] & ~(mode[k] ^ field[k]);
  end

  assign pred = fold_terms(terms, use_or);

endmodule

// File: rtl/pbp_seq.sv
module pbp_seq #(
  parameter int LEN_W      = 7,
  parameter int MAX_SCALAR = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             vec_in,
  output logic             load,
  output logic             busy,
  output logic             fire,
  output logic             last,
  output logic [LEN_W-1:0] idx,
  output logic             done
);
  import pbp_pkg::*;

  localparam logic [LEN_W-1:0] SCALAR_CAP = LEN_W'(MAX_SCALAR);

  pbp_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] eff_len;
  logic             zero_len;

  assign eff_len  = (!vec_in && (len_in > SCALAR_CAP)) ? SCALAR_CAP : len_in;
  assign zero_len = (eff_len == '0);
  assign load     = (state_q == ST_IDLE) && start;
  assign busy     = (state_q != ST_IDLE);
  assign fire     = (state_q == ST_RUN);
  assign last     = fire && (idx_q == len_q - LEN_W'(1));
  assign idx      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            len_q <= eff_len;
            idx_q <= '0;
            if (zero_len) done <= 1'b1;
            else          state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          idx_q <= idx_q + LEN_W'(1);
          if (last) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the element counter stays inside the captured length
  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (idx_q < len_q));

  // R13: a start pulse during a run leaves the captured length alone
  p_start_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && start) |=> (len_q == $past(len_q)));

  // R12: scalar runs never exceed the cap
  p_scalar_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !vec_in) |=> (len_q <= SCALAR_CAP));

endmodule

// File: rtl/pbp_packer.sv
module pbp_packer #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 7,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              fire,
  input  logic              last,
  input  logic [LEN_W-1:0]  idx,
  input  logic              pred,
  input  logic              vec,
  input  logic [1:0]        width,
  input  logic [REG_W-1:0]  base,
  output logic              wr_valid,
  output logic [REG_W-1:0]  wr_reg,
  output logic [DATA_W-1:0] wr_data
);
  import pbp_pkg::*;

  localparam int POS_W = $clog2(DATA_W);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_next;
  logic [LEN_W-1:0]  slot;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  group;
  logic              group_end;
  logic              flush;

  assign slot      = idx & slot_mask(width);
  assign pos       = vec ? POS_W'(slot) : POS_W'(idx);
  assign group     = idx >> width;
  assign group_end = vec && (slot == slot_mask(width));
  assign flush     = fire && (group_end || last);
  assign acc_next  = acc_q | (DATA_W'(pred) << pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      wr_valid <= 1'b0;
      wr_reg   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= flush;
      if (load) begin
        acc_q <= '0;
      end else if (fire) begin
        acc_q <= flush ? '0 : acc_next;
      end
      if (flush) begin
        wr_data <= acc_next;
        wr_reg  <= vec ? (base + REG_W'(group)) : base;
      end
    end
  end

  // R3, R4, R5, R6: bits above the group are zero in vector writes
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && vec) |-> ((wr_data >> (7'd1 << width)) == '0));

  // R7: scalar writes always target the base register
  p_scalar_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !vec) |-> (wr_reg == base));

  // R9: the accumulator is empty again after every write
  p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (acc_q == '0));

endmodule

// File: rtl/pbp_unit.sv
module pbp_unit #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 7,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cfg_mask,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_any,
  input  logic [1:0]        cfg_width,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [REG_W-1:0]  cfg_base,
  input  logic              cfg_vec,
  output logic [LEN_W-1:0]  fld_idx,
  input  logic [3:0]        fld_bits,
  output logic              wr_valid,
  output logic [REG_W-1:0]  wr_reg,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);

  logic [3:0]       mask_q;
  logic [3:0]       mode_q;
  logic             any_q;
  logic [1:0]       width_q;
  logic [REG_W-1:0] base_q;
  logic             vec_q;

  logic             load;
  logic             fire;
  logic             last;
  logic [LEN_W-1:0] idx;
  logic [3:0]       terms;
  logic             pred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '0;
      any_q   <= 1'b0;
      width_q <= '0;
      base_q  <= '0;
      vec_q   <= 1'b0;
    end else if (load) begin
      mask_q  <= cfg_mask;
      mode_q  <= cfg_mode;
      any_q   <= cfg_any;
      width_q <= cfg_width;
      base_q  <= cfg_base;
      vec_q   <= cfg_vec;
    end
  end

  pbp_seq #(.LEN_W(LEN_W), .MAX_SCALAR(DATA_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .len_in (cfg_len),
    .vec_in (cfg_vec),
    .load   (load),
    .busy   (busy),
    .fire   (fire),
    .last   (last),
    .idx    (idx),
    .done   (done)
  );

  pbp_reduce u_reduce (
    .mask   (mask_q),
    .mode   (mode_q),
    .field  (fld_bits),
    .use_or (any_q),
    .terms  (terms),
    .pred   (pred)
  );

  pbp_packer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .REG_W(REG_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .fire     (fire),
    .last     (last),
    .idx      (idx),
    .pred     (pred),
    .vec      (vec_q),
    .width    (width_q),
    .base     (base_q),
    .wr_valid (wr_valid),
    .wr_reg   (wr_reg),
    .wr_data  (wr_data)
  );

  assign fld_idx = idx;

  // R10: no write request during the completion pulse
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  // R1: a masked-off position never contributes a true term
  p_mask_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((terms & ~mask_q) == 4'b0000));

  // R2: an AND reduction needs every mask bit set to give 1
  p_and_full_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !any_q && pred) |-> (mask_q == 4'b1111));

endmodule

// File: tb/pbp_unit_test.sv
module pbp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_mask = '0;
  logic [3:0]  cfg_mode = '0;
  logic        cfg_any = 1'b0;
  logic [1:0]  cfg_width = '0;
  logic [6:0]  cfg_len = '0;
  logic [4:0]  cfg_base = '0;
  logic        cfg_vec = 1'b0;
  logic [6:0]  fld_idx;
  logic [3:0]  fld_bits;
  logic        wr_valid;
  logic [4:0]  wr_reg;
  logic [63:0] wr_data;
  logic        busy;
  logic        done;

  logic [3:0]  fields [128];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  assign fld_bits = fields[fld_idx];

  pbp_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_mask(cfg_mask), .cfg_mode(cfg_mode), .cfg_any(cfg_any),
    .cfg_width(cfg_width), .cfg_len(cfg_len), .cfg_base(cfg_base),
    .cfg_vec(cfg_vec), .fld_idx(fld_idx), .fld_bits(fld_bits),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_pred(input logic [3:0] m, input logic [3:0] p,
                                  input logic [3:0] f, input bit any);
    int hits = 0;
    int live = 0;
    for (int k = 0; k < 4; k++) begin
      if (m[k]) begin
        live++;
        if (p[k] == f[k]) hits++;
      end
    end
    if (any) return hits > 0;
    return (live == 4) && (hits == 4);
  endfunction

  task automatic fill_fields(input int kind, input logic [3:0] pat);
    for (int i = 0; i < 128; i++)
      fields[i] = (kind == 0) ? 4'($urandom) : pat;
  endtask

  // glitch: cycle index at which a foreign start pulse is raised, -1 for none
  task automatic run(input logic [3:0] m, input logic [3:0] p, input bit any,
                     input logic [1:0] w, input int len, input logic [4:0] base,
                     input bit vec, input int glitch);
    bit          ev [0:131];
    logic [4:0]  er [0:131];
    logic [63:0] ed [0:131];
    logic [63:0] acc = '0;
    int L;
    int G;
    int done_k;
    string dtag;
    L = vec ? len : ((len > 64) ? 64 : len);
    G = 1 << w;
    for (int k = 0; k < 132; k++) begin ev[k] = 0; er[k] = '0; ed[k] = '0; end
    for (int i = 0; i < L; i++) begin
      int pos;
      bit fl;
      pos = vec ? (i % G) : i;
      if (ref_pred(m, p, fields[i], any)) acc = acc | (64'd1 << pos);
      fl = vec ? ((pos == G - 1) || (i == L - 1)) : (i == L - 1);
      if (fl) begin
        ev[i + 1] = 1;
        er[i + 1] = vec ? 5'((int'(base) + i / G) % 32) : base;
        ed[i + 1] = acc;
        acc = '0;
      end
    end
    done_k = (L == 0) ? 0 : L + 1;
    dtag = vec ? $sformatf("R%0d", 3 + w) : "R7";

    @(negedge clk);
    cfg_mask = m; cfg_mode = p; cfg_any = any; cfg_width = w;
    cfg_len = 7'(len); cfg_base = base; cfg_vec = vec;
    start = 1'b1;
    for (int k = 0; k <= L + 2; k++) begin
      @(posedge clk);
      #1;
      if (k == 0) start = 1'b0;
      if (k == glitch) begin
        start = 1'b1;
        cfg_mask = ~m; cfg_mode = ~p; cfg_any = ~any; cfg_width = ~w;
        cfg_len = 7'd3; cfg_base = ~base; cfg_vec = ~vec;
      end
      if (k == glitch + 1) start = 1'b0;
      check((glitch >= 0) ? "R13" : "R9", $sformatf("wr_valid k=%0d", k),
            64'(wr_valid), 64'(ev[k]));
      if (ev[k] && wr_valid) begin
        check(dtag, $sformatf("wr_reg k=%0d", k), 64'(wr_reg), 64'(er[k]));
        check(dtag, $sformatf("wr_data k=%0d", k), wr_data, ed[k]);
      end
      check((L == 0) ? "R11" : "R10", $sformatf("done k=%0d", k),
            64'(done), 64'(k == done_k));
      if (k < L) begin
        check("R8", $sformatf("fld_idx k=%0d", k), 64'(fld_idx), 64'(k));
        check("R8", $sformatf("busy k=%0d", k), 64'(busy), 64'd1);
      end
    end
    start = 1'b0;
    check("R10", "idle after run", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset done", 64'(done), 64'd0);
    check("R9", "reset wr_valid", 64'(wr_valid), 64'd0);
    check("R8", "reset busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);

    fill_fields(0, 4'h0);
    // R3 R4 R5 R6: every width code with a final partial group
    for (int w = 0; w < 4; w++) begin
      run(4'b1011, 4'b0110, 1'b1, 2'(w), 13, 5'd2, 1'b1, -1);
      run(4'b1111, 4'b0101, 1'b0, 2'(w), 13, 5'd7, 1'b1, -1);
    end
    // R3 with register wrap, long vector
    run(4'b0011, 4'b0001, 1'b1, 2'd0, 100, 5'd30, 1'b1, -1);
    run(4'b1100, 4'b1000, 1'b0, 2'd3, 100, 5'd30, 1'b1, -1);
    // R7: scalar accumulation above bit 8
    run(4'b0110, 4'b0010, 1'b1, 2'd0, 40, 5'd9, 1'b0, -1);
    // R12: scalar clamp and unclamped vector
    run(4'b0001, 4'b0001, 1'b1, 2'd2, 70, 5'd4, 1'b0, -1);
    run(4'b0001, 4'b0001, 1'b1, 2'd1, 70, 5'd4, 1'b1, -1);
    // R11: zero length, both modes
    run(4'b1111, 4'b0000, 1'b1, 2'd0, 0, 5'd1, 1'b1, -1);
    run(4'b1111, 4'b0000, 1'b1, 2'd0, 0, 5'd1, 1'b0, -1);
    // R1 R2: fixed fields
    fill_fields(1, 4'b1010);
    run(4'b1111, 4'b1010, 1'b0, 2'd3, 8, 5'd3, 1'b1, -1);
    run(4'b0000, 4'b1010, 1'b0, 2'd3, 8, 5'd3, 1'b1, -1);
    run(4'b0000, 4'b1010, 1'b1, 2'd3, 8, 5'd3, 1'b1, -1);
    run(4'b0100, 4'b0101, 1'b1, 2'd2, 6, 5'd3, 1'b1, -1);
    run(4'b0100, 4'b0000, 1'b1, 2'd2, 6, 5'd3, 1'b1, -1);
    run(4'b1111, 4'b1011, 1'b0, 2'd0, 3, 5'd3, 1'b0, -1);
    // R13: foreign start during a run
    fill_fields(0, 4'h0);
    run(4'b1101, 4'b0100, 1'b1, 2'd1, 20, 5'd12, 1'b1, 5);
    run(4'b0111, 4'b0011, 1'b0, 2'd0, 30, 5'd12, 1'b0, 10);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule